// File: doc/BRIEF.md
# Core-Clocked Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. It runs from the core clock. A power-of-two prescaler produces count ticks, and a down counter decrements once per tick. Software sets the timer up through a small word-wide register port. It writes a divide code, then a timer entry holding the interrupt vector, a mask bit and a mode bit, and finally an initial count. Writing the initial count starts the countdown.

In one-shot mode the count runs down to zero and holds there. One tick after the count reaches zero the block raises a single request. In periodic mode the count reloads from the initial value after the zero tick, so each period lasts initial count plus one ticks, and a request is raised once per period. The request is a one-cycle pulse that carries the vector from the entry. Software can read the current count at any time. A set mask bit keeps the counter running but stops every request.

Top module: `cdt_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), and the initial count, current count and divide code all read 0.
- R2: Register map on `reg_addr`: 0 is the timer entry (vector in bits 7:0, mask in bit 16, periodic in bit 17, all other bits read 0), 1 is the initial count, 2 is the current count (writes to it are ignored), and 3 is the divide code (bits 3, 1 and 0 kept, all other bits read 0).
- R3: The divide code c = {bit3, bit1, bit0} sets the tick length: c = 7 gives one tick per cycle, and c = 0 to 6 gives one tick every 2^(c+1) cycles.
- R4: A write to the initial count loads that value into the current count at the same edge and restarts the prescaler, so the count after edge E+n (load at edge E) has seen n >> shift ticks.
- R5: In one-shot mode the current count is initial minus ticks, and it stays at zero once the tick count reaches the initial value.
- R6: In one-shot mode with a nonzero initial count, exactly one pulse appears on `tmr_irq` in the cycle after edge E + ((initial+1) << shift), and `tmr_vec` carries the entry vector.
- R7: In periodic mode the count reads initial minus (ticks mod (initial+1)), and a pulse appears after every edge E + k*((initial+1) << shift), k >= 1.
- R8: In periodic mode with an initial count of zero, no pulse is ever raised.
- R9: While the mask bit is set, no pulse is raised and the count keeps running. A one-shot expiry that passes while masked does not fire when the mask is cleared afterwards.
- R10: A write to the initial count at the same edge as an expiry cancels that expiry, and the countdown restarts from the new value.
- R11: A one-shot load of zero never raises a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tmr_irq | output | 1 | One-cycle timer request pulse |
| tmr_vec | output | 8 | Vector that goes with the pulse |

## Verification
The collision that matters is an initial-count write landing on the same edge as the zero tick that would raise a request. The bench loads a one-shot count of 3 with a divide of 1, then lines up a reload of 5 on exactly the fourth edge after the load. The scoreboard expects a single pulse, six edges after the reload, and nothing at the original expiry edge. Any early or extra pulse shows up as a mismatch against the queued cycle.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int VEC_W     = 8;
  localparam int SHIFT_W   = 3;
  localparam int PRE_W     = 7;   // enough for the largest shift

  localparam logic [1:0] A_ENTRY = 2'd0;
  localparam logic [1:0] A_INIT  = 2'd1;
  localparam logic [1:0] A_CUR   = 2'd2;
  localparam logic [1:0] A_DIV   = 2'd3;

  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // divide code 7 -> shift 0, codes 0..6 -> shift 1..7
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    if (code == 3'd7) return '0;
    else              return code + 3'd1;
  endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output entry_t            entry,
  output logic [CNT_W-1:0]  init_cnt,
  output logic [2:0]        div_code,
  output logic              load,
  output logic [DATA_W-1:0] rdata
);

  entry_t             entry_q, entry_d;
  logic [CNT_W-1:0]   init_q, init_d;
  logic [2:0]         div_q, div_d;
  logic               ent_we, init_we, div_we;

  assign ent_we  = wr_en && (addr == A_ENTRY);
  assign init_we = wr_en && (addr == A_INIT);
  assign div_we  = wr_en && (addr == A_DIV);

  always_comb begin
    entry_d = entry_q;
    init_d  = init_q;
    div_d   = div_q;
    if (ent_we) begin
      entry_d.vec      = wdata[VEC_W-1:0];
      entry_d.mask     = wdata[ENT_MASK_BIT];
      entry_d.periodic = wdata[ENT_PER_BIT];
    end
    if (init_we) init_d = wdata[CNT_W-1:0];
    if (div_we)  div_d  = {wdata[3], wdata[1], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q.periodic <= 1'b0;
      entry_q.mask     <= 1'b1;
      entry_q.vec      <= '0;
      init_q           <= '0;
      div_q            <= '0;
    end else begin
      if (ent_we)  entry_q <= entry_d;
      if (init_we) init_q  <= init_d;
      if (div_we)  div_q   <= div_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ENTRY: begin
        rdata[VEC_W-1:0]   = entry_q.vec;
        rdata[ENT_MASK_BIT] = entry_q.mask;
        rdata[ENT_PER_BIT]  = entry_q.periodic;
      end
      A_INIT:  rdata[CNT_W-1:0] = init_q;
      A_CUR:   rdata[CNT_W-1:0] = cur_cnt;
      default: begin
        rdata[3] = div_q[2];
        rdata[1] = div_q[1];
        rdata[0] = div_q[0];
      end
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  assign entry    = entry_q;
  assign init_cnt = init_q;
  assign div_code = div_q;
  assign load     = init_we;

  // R2
  entry_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |=> (entry_q.vec == $past(wdata[VEC_W-1:0])) &&
               (entry_q.mask == $past(wdata[ENT_MASK_BIT])));

  // R2
  div_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> rdata_div_ok(div_q, $past(wdata[3:0])));

  function automatic logic rdata_div_ok(input logic [2:0] q, input logic [3:0] w);
    return q == {w[3], w[1], w[0]};
  endfunction

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] span_mask;

  assign span_mask = (PRE_W'(1) << shift) - PRE_W'(1);

  always_comb begin
    if (restart) pre_d = '0;
    else         pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = ((pre_q & span_mask) == span_mask);

  // R3
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == '0) |-> tick);

  // R4
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && shift != '0 && $stable(shift)) |=> (!tick || shift != $past(shift)));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic             tick,
  input  entry_t           entry,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);

  logic [CNT_W-1:0] cur_q, cur_d;
  logic             done_q, done_d;
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             at_zero, expire;

  assign at_zero = (cur_q == '0);

  always_comb begin
    cur_d  = cur_q;
    done_d = done_q;
    expire = 1'b0;
    if (load) begin
      cur_d  = load_val;
      done_d = 1'b0;
    end else if (tick) begin
      if (!at_zero) begin
        cur_d = cur_q - CNT_W'(1);
      end else begin
        if (entry.periodic) cur_d = init_cnt;
        if (init_cnt != '0 && (entry.periodic || !done_q)) expire = 1'b1;
        if (!entry.periodic) done_d = 1'b1;
      end
    end
    irq_d = expire && !entry.mask;
    vec_d = irq_d ? entry.vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      done_q <= done_d;
      irq_q  <= irq_d;
      if (irq_d) vec_q <= vec_d;
    end
  end

  assign cur_cnt = cur_q;
  assign irq     = irq_q;
  assign irq_vec = vec_q;

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_q == $past(load_val));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !entry.periodic && at_zero) |=> cur_q == '0);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry.periodic && init_cnt == '0 && !load) |=> !irq_q);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(entry.mask));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !irq_q);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tmr_irq,
  output logic [VEC_W-1:0]  tmr_vec
);

  entry_t             entry;
  logic [CNT_W-1:0]   init_cnt;
  logic [CNT_W-1:0]   cur_cnt;
  logic [2:0]         div_code;
  logic               load;
  logic               tick;
  logic [SHIFT_W-1:0] shift;

  assign shift = code_to_shift(div_code);

  cdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .cur_cnt  (cur_cnt),
    .entry    (entry),
    .init_cnt (init_cnt),
    .div_code (div_code),
    .load     (load),
    .rdata    (reg_rdata)
  );

  cdt_prescaler pre_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .shift   (shift),
    .tick    (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (reg_wdata[CNT_W-1:0]),
    .init_cnt (init_cnt),
    .tick     (tick),
    .entry    (entry),
    .cur_cnt  (cur_cnt),
    .irq      (tmr_irq),
    .irq_vec  (tmr_vec)
  );

endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tmr_irq;
  logic [7:0]  tmr_vec;

  int unsigned cyc = 0;
  int tests = 0;
  int fails = 0;
  string cur_req = "R1";

  typedef struct {
    int unsigned at;
    logic [7:0]  vec;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_irq(tmr_irq), .tmr_vec(tmr_vec)
  );

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int unsigned edge_no);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_to(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(input int unsigned t, input logic [7:0] v, input string r);
    exp_t e;
    e.at = t; e.vec = v; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic chk_empty(input string r);
    chk(r, "pending expected pulses", sb_q.size(), 0);
  endtask

  // monitor: compare every pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && tmr_irq) begin
      if (sb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL %s unexpected pulse at cycle %0d: got 1 expected 0", cur_req, cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, "pulse cycle", cyc, e.at);
        chk(e.req, "pulse vector", tmr_vec, e.vec);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned e, e2, dummy;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    rd(2'd0, d); chk("R1", "entry after reset", d, 32'h0001_0000);
    rd(2'd1, d); chk("R1", "initial after reset", d, 0);
    rd(2'd2, d); chk("R1", "current after reset", d, 0);
    rd(2'd3, d); chk("R1", "divide after reset", d, 0);

    // R2 field layout and read-only current count
    cur_req = "R2";
    @(negedge clk);
    wr(2'd0, 32'hFFFF_FFFF, dummy);
    rd(2'd0, d); chk("R2", "entry field mask", d, 32'h0003_00FF);
    @(negedge clk);
    wr(2'd3, 32'hFFFF_FFFF, dummy);
    rd(2'd3, d); chk("R2", "divide field mask", d, 32'h0000_000B);
    @(negedge clk);
    wr(2'd2, 32'h0000_1234, dummy);
    rd(2'd2, d); chk("R2", "current ignores write", d, 0);

    // R4 R5 R6 one-shot, divide by 1
    cur_req = "R6";
    @(negedge clk);
    wr(2'd3, 32'h0000_000B, dummy);
    wr(2'd0, 32'h0000_0031, dummy);
    wr(2'd1, 32'd5, e);
    push(e + 6, 8'h31, "R6");
    rd(2'd2, d); chk("R4", "count loaded", d, 5);
    wait_to(e + 2);
    rd(2'd2, d); chk("R5", "one-shot count mid", d, 3);
    wait_to(e + 20);
    rd(2'd2, d); chk("R5", "one-shot saturates", d, 0);
    chk_empty("R6");

    // R3 divide by 4 (code 1) and by 32 (code 4 = bit3 set)
    cur_req = "R3";
    wr(2'd3, 32'h0000_0001, dummy);
    wr(2'd1, 32'd3, e);
    push(e + 16, 8'h31, "R3");
    wait_to(e + 9);
    rd(2'd2, d); chk("R3", "count at divide 4", d, 1);
    wait_to(e + 30);
    chk_empty("R3");
    wr(2'd3, 32'h0000_0008, dummy);
    wr(2'd1, 32'd1, e);
    push(e + 64, 8'h31, "R3");
    wait_to(e + 40);
    rd(2'd2, d); chk("R3", "count at divide 32", d, 0);
    wait_to(e + 70);
    chk_empty("R3");

    // R7 periodic, then R8 zero reload
    cur_req = "R7";
    wr(2'd3, 32'h0000_000B, dummy);
    wr(2'd0, 32'h0002_0042, dummy);
    wr(2'd1, 32'd2, e);
    for (int k = 1; k <= 4; k++) push(e + 3*k, 8'h42, "R7");
    wait_to(e + 4);
    rd(2'd2, d); chk("R7", "periodic count", d, 1);
    wait_to(e + 12);
    rd(2'd2, d); chk("R7", "periodic reload", d, 2);
    wait_to(e + 13);
    cur_req = "R8";
    wr(2'd1, 32'd0, dummy);
    repeat (40) @(negedge clk);
    rd(2'd2, d); chk("R8", "periodic zero count", d, 0);
    chk_empty("R7");

    // R9 masked one-shot, then unmask after expiry
    cur_req = "R9";
    wr(2'd0, 32'h0001_0050, dummy);
    wr(2'd1, 32'd2, e);
    wait_to(e + 20);
    rd(2'd2, d); chk("R9", "masked one-shot still counts", d, 0);
    wr(2'd0, 32'h0000_0050, dummy);
    repeat (20) @(negedge clk);
    chk_empty("R9");
    // R9 masked periodic keeps counting
    wr(2'd0, 32'h0003_0050, dummy);
    wr(2'd1, 32'd1, e);
    wait_to(e + 7);
    rd(2'd2, d); chk("R9", "masked periodic count odd", d, 0);
    wait_to(e + 8);
    rd(2'd2, d); chk("R9", "masked periodic count even", d, 1);
    wait_to(e + 30);
    chk_empty("R9");

    // R10 reload on the expiry edge
    cur_req = "R10";
    wr(2'd0, 32'h0000_0066, dummy);
    wr(2'd1, 32'd3, e);
    wait_to(e + 3);
    wr(2'd1, 32'd5, e2);
    chk("R10", "reload lands on expiry edge", e2, e + 4);
    push(e2 + 6, 8'h66, "R10");
    wait_to(e2 + 12);
    chk_empty("R10");

    // R11 one-shot zero
    cur_req = "R11";
    wr(2'd1, 32'd0, e);
    repeat (30) @(negedge clk);
    rd(2'd2, d); chk("R11", "one-shot zero count", d, 0);
    chk_empty("R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule